// File: doc/BRIEF.md
# Physical Register Readiness Tracker with Wakeup

This block keeps one readiness bit for every physical register and a small set of waiting slots. A dispatching instruction is written into a slot with up to two source tags and an optional destination tag. Each source starts out ready if it arrives flagged as ready, if its tag lies outside the tracked register range, if its readiness bit is already set, or if a completion for that very tag arrives in the same cycle. Any other source stays in the slot and waits. The destination's readiness bit is cleared, because the new instruction is now the register's pending producer.

A completion carries one destination tag. It sets that register's readiness bit, and every valid slot whose waiting source holds the same tag is marked ready at that clock edge, through a parallel tag compare in every slot. When all sources of a valid slot are ready, the slot raises a one-cycle ready-to-issue pulse for the selection logic that follows. A squash mask invalidates chosen slots so that they ignore later completions. If a dispatch names as its destination a register that a valid slot is still waiting on, a conflict flag is raised in that cycle.

Top module: `phys_scoreboard_wakeup`

## Requirements
- R1: After reset every readiness bit is clear and no slot is valid, so `issue_ready` is zero and a source dispatched unflagged with an in-range tag waits.
- R2: A dispatch with `disp_has_dst` high and an in-range `disp_dst_tag` clears that register's readiness bit at the dispatch edge.
- R3: A source with its `disp_src_rdy` bit high is ready from dispatch and is never tracked.
- R4: An unflagged source whose readiness bit is set, or whose tag equals an in-range `cmp_tag` completing in the same cycle, is ready from dispatch.
- R5: A completion with an in-range tag sets that readiness bit and marks ready, at the same edge, the matching waiting source of every valid slot.
- R6: `issue_ready[i]` is high for exactly one cycle: the cycle after the edge at which slot i was loaded or woken with all sources ready.
- R7: Tags at or above NUM_PREGS are ignored. Such sources are ready at dispatch, such destinations clear nothing and raise no conflict, and such completions wake nothing.
- R8: `dst_conflict` is high, in the same cycle and without a register, when a dispatch's in-range destination equals the tag of a still-waiting source in any valid slot.
- R9: A slot whose `squash_mask` bit is high becomes invalid at that edge, ignores later completions and does not pulse. A dispatch to the same slot in the same cycle takes priority over the squash.
- R10: When a dispatch clears and a completion sets the same register in one cycle, the bit ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_entry | input | $clog2(NUM_ENTRIES) | Slot index written by the dispatch |
| disp_src_tag | input | NUM_SRC x TAG_W | Source register tags |
| disp_src_rdy | input | NUM_SRC | Source already known ready |
| disp_has_dst | input | 1 | Dispatch writes a destination |
| disp_dst_tag | input | TAG_W | Destination register tag |
| cmp_valid | input | 1 | Completion broadcast this cycle |
| cmp_tag | input | TAG_W | Register produced by the completion |
| squash_mask | input | NUM_ENTRIES | Slots to invalidate |
| issue_ready | output | NUM_ENTRIES | One-cycle ready-to-issue pulse per slot |
| dst_conflict | output | 1 | Dispatch destination still has waiters |

## Verification
Directed cases first separate the ways a source can become ready: a flag at dispatch, a bit that is already set, a completion in the same cycle, and a later completion. They also show that a fresh destination clear makes a later consumer wait. Boundary cases cover tags just past the tracked range, a completion that wakes two slots at once, a squashed slot that receives its completion, and a dispatch clear that collides with a completion on the same register. A seeded random phase then mixes dispatches, completions and squashes over a narrow tag pool, so that tags collide often. Each cycle it compares the pulses and the conflict flag with a reference model held in the bench.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

    localparam int SBW_PREGS   = 32;
    localparam int SBW_TAG_W   = 6;
    localparam int SBW_ENTRIES = 8;
    localparam int SBW_SRCS    = 2;

    typedef struct packed {
        logic [SBW_TAG_W-1:0] tag;
        logic                 rdy;
    } src_t;

    function automatic logic tag_live(input logic [SBW_TAG_W-1:0] t,
                                      input int unsigned limit);
        return 32'(t) < limit;
    endfunction

endpackage

// File: rtl/sbw_board.sv
module sbw_board
    import sbw_pkg::*;
#(
    parameter int NUM_PREGS = SBW_PREGS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 set_en,
    input  logic [SBW_TAG_W-1:0] set_tag,
    input  logic                 clr_en,
    input  logic [SBW_TAG_W-1:0] clr_tag,
    output logic [NUM_PREGS-1:0] ready_bits
);
    localparam int PIDX_W = (NUM_PREGS > 1) ? $clog2(NUM_PREGS) : 1;

    logic [PIDX_W-1:0] set_idx;
    logic [PIDX_W-1:0] clr_idx;

    assign set_idx = set_tag[PIDX_W-1:0];
    assign clr_idx = clr_tag[PIDX_W-1:0];

    for (genvar p = 0; p < NUM_PREGS; p++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                ready_bits[p] <= 1'b0;
            end else if (clr_en && clr_idx == PIDX_W'(p)) begin
                // a new producer claims the register: clear wins over set
                ready_bits[p] <= 1'b0;
            end else if (set_en && set_idx == PIDX_W'(p)) begin
                ready_bits[p] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sbw_slot.sv
module sbw_slot
    import sbw_pkg::*;
#(
    parameter int NUM_SRC = SBW_SRCS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  src_t [NUM_SRC-1:0]   load_src,
    input  logic                 squash,
    input  logic                 wake_en,
    input  logic [SBW_TAG_W-1:0] wake_tag,
    output logic                 valid,
    output src_t [NUM_SRC-1:0]   src_q,
    output logic                 req
);
    logic fired_q;
    logic all_rdy;

    always_comb begin
        all_rdy = 1'b1;
        for (int s = 0; s < NUM_SRC; s++) begin
            all_rdy = all_rdy & src_q[s].rdy;
        end
    end

    assign req = valid && all_rdy && !fired_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            fired_q <= 1'b0;
            src_q   <= '0;
        end else if (load) begin
            valid   <= 1'b1;
            fired_q <= 1'b0;
            src_q   <= load_src;
        end else begin
            if (squash) begin
                valid <= 1'b0;
            end
            if (req) begin
                fired_q <= 1'b1;
            end
            for (int s = 0; s < NUM_SRC; s++) begin
                if (valid && wake_en && src_q[s].tag == wake_tag) begin
                    src_q[s].rdy <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/phys_scoreboard_wakeup.sv
module phys_scoreboard_wakeup
    import sbw_pkg::*;
#(
    parameter int NUM_PREGS   = SBW_PREGS,
    parameter int NUM_ENTRIES = SBW_ENTRIES,
    parameter int NUM_SRC     = SBW_SRCS
) (
    input  logic                                        clk,
    input  logic                                        rst,
    input  logic                                        disp_valid,
    input  logic [$clog2(NUM_ENTRIES)-1:0]              disp_entry,
    input  logic [NUM_SRC-1:0][SBW_TAG_W-1:0]           disp_src_tag,
    input  logic [NUM_SRC-1:0]                          disp_src_rdy,
    input  logic                                        disp_has_dst,
    input  logic [SBW_TAG_W-1:0]                        disp_dst_tag,
    input  logic                                        cmp_valid,
    input  logic [SBW_TAG_W-1:0]                        cmp_tag,
    input  logic [NUM_ENTRIES-1:0]                      squash_mask,
    output logic [NUM_ENTRIES-1:0]                      issue_ready,
    output logic                                        dst_conflict
);
    localparam int ENT_W  = $clog2(NUM_ENTRIES);
    localparam int PIDX_W = (NUM_PREGS > 1) ? $clog2(NUM_PREGS) : 1;

    logic [NUM_PREGS-1:0]   sb_bits;
    logic                   wake_en;
    logic                   clr_en;
    src_t [NUM_SRC-1:0]     init_src;
    logic [NUM_ENTRIES-1:0] slot_valid;
    src_t [NUM_SRC-1:0]     slot_src [NUM_ENTRIES];
    logic                   waiter_hit;

    assign wake_en = cmp_valid && tag_live(cmp_tag, NUM_PREGS);
    assign clr_en  = disp_valid && disp_has_dst && tag_live(disp_dst_tag, NUM_PREGS);

    sbw_board #(.NUM_PREGS(NUM_PREGS)) u_board (
        .clk        (clk),
        .rst        (rst),
        .set_en     (wake_en),
        .set_tag    (cmp_tag),
        .clr_en     (clr_en),
        .clr_tag    (disp_dst_tag),
        .ready_bits (sb_bits)
    );

    // readiness of each source as it enters a slot, including a
    // completion arriving in the same cycle
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            init_src[s].tag = disp_src_tag[s];
            if (!tag_live(disp_src_tag[s], NUM_PREGS)) begin
                init_src[s].rdy = 1'b1;
            end else begin
                init_src[s].rdy = disp_src_rdy[s]
                               || sb_bits[disp_src_tag[s][PIDX_W-1:0]]
                               || (wake_en && cmp_tag == disp_src_tag[s]);
            end
        end
    end

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_slot
        sbw_slot #(.NUM_SRC(NUM_SRC)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .load     (disp_valid && disp_entry == ENT_W'(e)),
            .load_src (init_src),
            .squash   (squash_mask[e]),
            .wake_en  (wake_en),
            .wake_tag (cmp_tag),
            .valid    (slot_valid[e]),
            .src_q    (slot_src[e]),
            .req      (issue_ready[e])
        );
    end

    always_comb begin
        waiter_hit = 1'b0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (slot_valid[e] && !slot_src[e][s].rdy
                    && slot_src[e][s].tag == disp_dst_tag) begin
                    waiter_hit = 1'b1;
                end
            end
        end
    end

    assign dst_conflict = clr_en && waiter_hit;

endmodule

// File: rtl/sbw_checker.sv
module sbw_checker
    import sbw_pkg::*;
#(
    parameter int NUM_PREGS   = SBW_PREGS,
    parameter int NUM_ENTRIES = SBW_ENTRIES,
    parameter int NUM_SRC     = SBW_SRCS
) (
    input logic                               clk,
    input logic                               rst,
    input logic                               disp_valid,
    input logic [$clog2(NUM_ENTRIES)-1:0]     disp_entry,
    input logic                               disp_has_dst,
    input logic [SBW_TAG_W-1:0]               disp_dst_tag,
    input logic                               cmp_valid,
    input logic [NUM_ENTRIES-1:0]             squash_mask,
    input logic [NUM_ENTRIES-1:0]             issue_ready,
    input logic                               dst_conflict
);
    localparam int ENT_W = $clog2(NUM_ENTRIES);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> issue_ready == '0);

    // R8, and R7 for out-of-range destinations
    assert_conflict_gate_R8: assert property (@(posedge clk) disable iff (rst)
        dst_conflict |-> (disp_valid && disp_has_dst
                          && tag_live(disp_dst_tag, NUM_PREGS)));

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_chk
        assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
            (issue_ready[e] && !(disp_valid && disp_entry == ENT_W'(e)))
            |=> !issue_ready[e]);

        assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (rst)
            issue_ready[e] |-> ($past(disp_valid && disp_entry == ENT_W'(e))
                                || $past(cmp_valid)));

        assert_squash_quiet_R9: assert property (@(posedge clk) disable iff (rst)
            (squash_mask[e] && !(disp_valid && disp_entry == ENT_W'(e)))
            |=> !issue_ready[e]);
    end

endmodule

bind phys_scoreboard_wakeup sbw_checker #(
    .NUM_PREGS   (NUM_PREGS),
    .NUM_ENTRIES (NUM_ENTRIES),
    .NUM_SRC     (NUM_SRC)
) u_sbw_checker (
    .clk          (clk),
    .rst          (rst),
    .disp_valid   (disp_valid),
    .disp_entry   (disp_entry),
    .disp_has_dst (disp_has_dst),
    .disp_dst_tag (disp_dst_tag),
    .cmp_valid    (cmp_valid),
    .squash_mask  (squash_mask),
    .issue_ready  (issue_ready),
    .dst_conflict (dst_conflict)
);

// File: tb/phys_scoreboard_wakeup_test.sv
module phys_scoreboard_wakeup_test;
    import sbw_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP = SBW_PREGS;
    localparam int NE = SBW_ENTRIES;
    localparam int NS = SBW_SRCS;
    localparam int TW = SBW_TAG_W;
    localparam int EW = $clog2(NE);

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   disp_valid;
    logic [EW-1:0]          disp_entry;
    logic [NS-1:0][TW-1:0]  disp_src_tag;
    logic [NS-1:0]          disp_src_rdy;
    logic                   disp_has_dst;
    logic [TW-1:0]          disp_dst_tag;
    logic                   cmp_valid;
    logic [TW-1:0]          cmp_tag;
    logic [NE-1:0]          squash_mask;
    logic [NE-1:0]          issue_ready;
    logic                   dst_conflict;

    phys_scoreboard_wakeup uut (
        .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_entry(disp_entry),
        .disp_src_tag(disp_src_tag), .disp_src_rdy(disp_src_rdy),
        .disp_has_dst(disp_has_dst), .disp_dst_tag(disp_dst_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .squash_mask(squash_mask),
        .issue_ready(issue_ready), .dst_conflict(dst_conflict)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model
    bit          m_sb    [NP];
    bit          m_val   [NE];
    bit          m_fired [NE];
    logic [TW-1:0] m_tag [NE][NS];
    bit          m_rdy   [NE][NS];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit live(input logic [TW-1:0] t);
        return 32'(t) < NP;
    endfunction

    function automatic logic [NE-1:0] exp_ready();
        logic [NE-1:0] r;
        for (int e = 0; e < NE; e++) begin
            bit all = 1'b1;
            for (int s = 0; s < NS; s++) all = all & m_rdy[e][s];
            r[e] = m_val[e] && all && !m_fired[e];
        end
        return r;
    endfunction

    function automatic logic exp_conflict();
        bit hit = 1'b0;
        if (!(disp_valid && disp_has_dst && live(disp_dst_tag))) return 1'b0;
        for (int e = 0; e < NE; e++)
            for (int s = 0; s < NS; s++)
                if (m_val[e] && !m_rdy[e][s] && m_tag[e][s] == disp_dst_tag) hit = 1'b1;
        return hit;
    endfunction

    task automatic model_edge();
        logic [NE-1:0] req = exp_ready();
        bit wk = cmp_valid && live(cmp_tag);
        bit init [NS];
        bit old_val [NE];
        for (int s = 0; s < NS; s++) begin
            logic [TW-1:0] t = disp_src_tag[s];
            init[s] = !live(t) || disp_src_rdy[s] || m_sb[t[4:0]] || (wk && cmp_tag == t);
        end
        for (int e = 0; e < NE; e++) old_val[e] = m_val[e];
        for (int e = 0; e < NE; e++) begin
            if (disp_valid && disp_entry == EW'(e)) begin
                m_val[e] = 1'b1; m_fired[e] = 1'b0;
                for (int s = 0; s < NS; s++) begin
                    m_tag[e][s] = disp_src_tag[s]; m_rdy[e][s] = init[s];
                end
            end else begin
                if (squash_mask[e]) m_val[e] = 1'b0;
                if (req[e]) m_fired[e] = 1'b1;
                for (int s = 0; s < NS; s++)
                    if (old_val[e] && wk && m_tag[e][s] == cmp_tag) m_rdy[e][s] = 1'b1;
            end
        end
        if (wk) m_sb[cmp_tag[4:0]] = 1'b1;
        if (disp_valid && disp_has_dst && live(disp_dst_tag)) m_sb[disp_dst_tag[4:0]] = 1'b0;
    endtask

    task automatic idle();
        disp_valid = 0; disp_entry = '0; disp_src_tag = '0; disp_src_rdy = '0;
        disp_has_dst = 0; disp_dst_tag = '0; cmp_valid = 0; cmp_tag = '0;
        squash_mask = '0;
    endtask

    task automatic disp(input int e, input int t0, input bit r0, input int t1,
                        input bit r1, input bit hd, input int dt);
        disp_valid = 1; disp_entry = EW'(e);
        disp_src_tag[0] = TW'(t0); disp_src_rdy[0] = r0;
        disp_src_tag[1] = TW'(t1); disp_src_rdy[1] = r1;
        disp_has_dst = hd; disp_dst_tag = TW'(dt);
    endtask

    task automatic complete(input int t);
        cmp_valid = 1; cmp_tag = TW'(t);
    endtask

    // one cycle: conflict before the edge, pulses after it
    task automatic cyc(input string req);
        #1;
        check({req, " conflict"}, 32'(dst_conflict), 32'(exp_conflict()));
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({req, " pulses"}, 32'(issue_ready), 32'(exp_ready()));
    endtask

    function automatic int rnd_tag();
        int r = int'($urandom % 16);
        if (r < 12) return r;
        if (r == 12) return 31;
        if (r == 13) return 32;
        return 40 + r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        for (int p = 0; p < NP; p++) m_sb[p] = 0;
        for (int e = 0; e < NE; e++) begin
            m_val[e] = 0; m_fired[e] = 0;
            for (int s = 0; s < NS; s++) begin m_tag[e][s] = '0; m_rdy[e][s] = 0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 reset pulses", 32'(issue_ready), 0);

        // R1: register 5 not ready after reset
        idle(); disp(0, 5, 0, 6, 1, 0, 0); cyc("R1");
        check("R1 waits after reset", 32'(issue_ready), 0);
        // R5: completion wakes the waiter
        idle(); complete(5); cyc("R5");
        check("R5 wake", 32'(issue_ready), 32'h01);
        // R6: pulse lasts a single cycle
        idle(); cyc("R6");
        check("R6 single pulse", 32'(issue_ready), 0);
        // R4: bit already set
        idle(); disp(1, 5, 0, 5, 0, 0, 0); cyc("R4");
        check("R4 set bit", 32'(issue_ready), 32'h02);
        // R3: flagged sources, destination 5 cleared
        idle(); disp(2, 3, 1, 3, 1, 1, 5); cyc("R3");
        check("R3 flagged", 32'(issue_ready), 32'h04);
        // R2: consumer of 5 now waits
        idle(); disp(3, 5, 0, 0, 1, 0, 0); cyc("R2");
        check("R2 dst cleared", 32'(issue_ready), 0);
        idle(); complete(5); cyc("R5");
        check("R5 wake after clear", 32'(issue_ready), 32'h08);
        // R7: tags beyond the range
        idle(); disp(4, 40, 0, 63, 0, 1, 33); cyc("R7");
        check("R7 out-of-range sources", 32'(issue_ready), 32'h10);
        idle(); complete(40); cyc("R7");
        check("R7 out-of-range completion", 32'(issue_ready), 0);
        // R8: destination with a waiter
        idle(); disp(5, 7, 0, 7, 1, 0, 0); cyc("R8");
        check("R8 waiter placed", 32'(issue_ready), 0);
        idle(); disp(6, 1, 1, 1, 1, 1, 7); #1;
        check("R8 conflict", 32'(dst_conflict), 1);
        cyc("R8");
        check("R8 producer slot", 32'(issue_ready), 32'h40);
        idle(); disp(7, 1, 1, 1, 1, 1, 45); #1;
        check("R7 no conflict out of range", 32'(dst_conflict), 0);
        cyc("R7");
        // R9: squashed slot ignores its completion
        idle(); squash_mask = 8'h20; cyc("R9");
        check("R9 squash", 32'(issue_ready), 0);
        idle(); complete(7); cyc("R9");
        check("R9 no wake after squash", 32'(issue_ready), 0);
        // R10: clear beats set
        idle(); disp(0, 1, 1, 1, 1, 1, 9); complete(9); cyc("R10");
        check("R10 producer slot", 32'(issue_ready), 32'h01);
        idle(); disp(1, 9, 0, 9, 0, 0, 0); cyc("R10");
        check("R10 clear wins", 32'(issue_ready), 0);
        // R4: completion in the dispatch cycle
        idle(); disp(2, 11, 0, 2, 1, 0, 0); complete(11); cyc("R4");
        check("R4 same-cycle completion", 32'(issue_ready), 32'h04);
        // R5: one completion wakes two slots
        idle(); disp(3, 12, 0, 12, 0, 0, 0); cyc("R5");
        idle(); disp(4, 13, 1, 12, 0, 0, 0); cyc("R5");
        check("R5 two waiters", 32'(issue_ready), 0);
        idle(); complete(12); cyc("R5");
        check("R5 broadcast", 32'(issue_ready), 32'h18);

        // seeded random mix against the model
        for (int i = 0; i < 600; i++) begin
            idle();
            if ($urandom % 2 == 0)
                disp(int'($urandom % NE), rnd_tag(), ($urandom % 4) == 0,
                     rnd_tag(), ($urandom % 4) == 0, ($urandom % 3) != 0, rnd_tag());
            if ($urandom % 5 < 2) complete(rnd_tag());
            if ($urandom % 20 == 0) squash_mask = NE'($urandom);
            cyc("R5 R6 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule